// File: doc/BRIEF.md
# Enclave TLB Fill Access Checker

This block sits behind a page-walk state machine and rules on whether a finished translation may be written into the TLB. Once the walker has produced a physical address, the requester strobes `req_valid` and presents, in the same cycle, the following inputs:

- the physical and virtual addresses of the walk;
- the privilege context, which is the enclave-mode flag and the running enclave's identifier;
- the protected-memory window and, nested inside it, the enclave page store window;
- the page-map entry that describes the target page;
- the linear window that the running enclave owns.

One clock later the block returns a one-cycle response. That response either allows the fill or refuses it with a 3-bit reason code. The reason code names the first check that failed.

The checks run in a fixed order, and the lowest-numbered failure is reported. Outside enclave mode only the protected window is policed. Inside enclave mode the block checks the placement of the physical page, and then the page's state, type, owner and allocation-time virtual page. The page walker, the TLB arrays and the page-map storage are outside the block.

Top module: `etlb_fill_guard`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. When `req_valid` is low, `rsp_code` keeps its last value and `rsp_allow`/`rsp_fault` stay low.
- R2: After reset, `rsp_valid`, `rsp_allow` and `rsp_fault` are 0 and `rsp_code` is 0.
- R3: With `enc_mode` low, a physical address inside the protected window [`prm_lo`, `prm_hi`) yields code 1. Any other address yields code 0, whatever the page-map inputs.
- R4: With `enc_mode` high, a physical address inside the protected window but outside the page store window [`epc_lo`, `epc_hi`) yields code 2.
- R5: With `enc_mode` high and the physical address outside the protected window, the result is code 2 if the virtual address lies in the enclave window, and code 0 otherwise. The enclave window is the set of addresses whose bits outside `rng_mask` equal those of `rng_base`.
- R6: With `enc_mode` high and the physical address in the page store window, a clear `pm_valid` yields code 2.
- R7: If the earlier checks pass and `pm_blocked` is set, the result is code 3.
- R8: If checks 1 to 3 pass, a page type whose bit in parameter `ACC_TYPES` is clear yields code 4. By default types 1 and 2 are accessible, and types 0 (control structure) and 3 are not.
- R9: If checks 1 to 4 pass and `pm_owner` differs from `enc_id`, the result is code 5.
- R10: If checks 1 to 5 pass and `req_va[VA_W-1:PG_SH]` differs from `pm_vpn`, the result is code 6. Otherwise the result is code 0.
- R11: In a response cycle, `rsp_allow` is high exactly when `rsp_code` is 0, and `rsp_fault` is its complement. The code never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A finished walk is presented this cycle |
| req_pa | input | PA_W | Physical address from the walk |
| req_va | input | VA_W | Virtual address being translated |
| enc_mode | input | 1 | Requester runs in enclave mode |
| enc_id | input | ID_W | Identifier of the running enclave |
| prm_lo | input | PA_W | Protected window start (inclusive) |
| prm_hi | input | PA_W | Protected window end (exclusive) |
| epc_lo | input | PA_W | Page store window start (inclusive) |
| epc_hi | input | PA_W | Page store window end (exclusive) |
| pm_valid | input | 1 | Page-map entry is in use |
| pm_blocked | input | 1 | Page is being evicted |
| pm_type | input | TYPE_W | Page type code |
| pm_owner | input | ID_W | Owning enclave identifier |
| pm_vpn | input | VA_W-PG_SH | Virtual page recorded at allocation |
| rng_base | input | VA_W | Enclave linear window base |
| rng_mask | input | VA_W | Enclave window size minus one (2^k-1) |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | Fill may be installed |
| rsp_fault | output | 1 | Fill is refused |
| rsp_code | output | 3 | First failing check, 0 when allowed |

## Verification
The hardest outcome to reach is a refusal from the owner or virtual-page check. Either one needs enclave mode and an address inside the page store window. It also needs a valid, unblocked entry of an accessible type, and, for the last check, a matching owner. Uniform random inputs almost never line all of these up. The stimulus therefore aims most physical addresses into the page store window and mostly copies the live enclave identifier and virtual page into the entry. It then breaks a single field with a small probability, and directed vectors cover each refusal individually.

// File: rtl/etlb_pkg.sv
package etlb_pkg;
   typedef enum logic [2:0] {
      CK_OK      = 3'd0,
      CK_HOSTPRM = 3'd1,
      CK_PLACE   = 3'd2,
      CK_BLOCKED = 3'd3,
      CK_TYPE    = 3'd4,
      CK_OWNER   = 3'd5,
      CK_VPAGE   = 3'd6
   } chk_code_e;

   localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/etlb_window.sv
// Address window membership, two encodings chosen at elaboration.
//   STYLE 0: bound_a <= addr < bound_b
//   STYLE 1: aligned power-of-two window, bound_a = base, bound_b = size-1
module etlb_window #(
   parameter int unsigned AW    = 32,
   parameter int unsigned STYLE = 0
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] bound_a,
   input  logic [AW-1:0] bound_b,
   output logic          hit
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("etlb_window: AW too small");
      end
      if (STYLE == 0) begin : g_span
         logic above_lo, below_hi;
         always_comb begin
            above_lo = (addr >= bound_a);
            below_hi = (addr <  bound_b);
            hit      = above_lo && below_hi;
         end
      end else if (STYLE == 1) begin : g_aligned
         logic [AW-1:0] keep;
         always_comb begin
            keep = ~bound_b;
            hit  = ((addr & keep) == (bound_a & keep));
         end
      end else begin : g_bad_style
         $error("etlb_window: unknown STYLE");
      end
   endgenerate
endmodule

// File: rtl/etlb_page_checks.sv
// Per-page metadata tests; each flag is raised when that test fails.
module etlb_page_checks #(
   parameter int unsigned ID_W      = 8,
   parameter int unsigned TYPE_W    = 2,
   parameter int unsigned VPN_W     = 20,
   parameter logic [(1<<TYPE_W)-1:0] ACC_TYPES = '1
) (
   input  logic              pm_valid,
   input  logic              pm_blocked,
   input  logic [TYPE_W-1:0] pm_type,
   input  logic [ID_W-1:0]   pm_owner,
   input  logic [VPN_W-1:0]  pm_vpn,
   input  logic [ID_W-1:0]   enc_id,
   input  logic [VPN_W-1:0]  va_vpn,
   output logic              f_invalid,
   output logic              f_blocked,
   output logic              f_type,
   output logic              f_owner,
   output logic              f_vpage
);
   localparam int unsigned NTYPES = 1 << TYPE_W;

   logic [NTYPES-1:0] type_hot;

   generate
      if (TYPE_W < 1 || TYPE_W > 6) begin : g_bad_tw
         $error("etlb_page_checks: TYPE_W out of range");
      end
      for (genvar t = 0; t < NTYPES; t++) begin : g_type
         assign type_hot[t] = (pm_type == TYPE_W'(t));
      end
   endgenerate

   always_comb begin
      f_invalid = !pm_valid;
      f_blocked = pm_blocked;
      f_type    = ((type_hot & ACC_TYPES) == '0);
      f_owner   = (pm_owner != enc_id);
      f_vpage   = (pm_vpn != va_vpn);
   end
endmodule

// File: rtl/etlb_verdict.sv
// Ordered resolution of the check results into a reason code.
module etlb_verdict
   import etlb_pkg::*;
(
   input  logic       enc_mode,
   input  logic       prm_hit,
   input  logic       epc_hit,
   input  logic       rng_hit,
   input  logic       f_invalid,
   input  logic       f_blocked,
   input  logic       f_type,
   input  logic       f_owner,
   input  logic       f_vpage,
   output chk_code_e  code
);
   always_comb begin
      code = CK_OK;
      if (!enc_mode) begin
         if (prm_hit) code = CK_HOSTPRM;
      end else if (!prm_hit) begin
         if (rng_hit) code = CK_PLACE;
      end else if (!epc_hit || f_invalid) begin
         code = CK_PLACE;
      end else if (f_blocked) begin
         code = CK_BLOCKED;
      end else if (f_type) begin
         code = CK_TYPE;
      end else if (f_owner) begin
         code = CK_OWNER;
      end else if (f_vpage) begin
         code = CK_VPAGE;
      end
   end
endmodule

// File: rtl/etlb_fill_guard.sv
module etlb_fill_guard
   import etlb_pkg::*;
#(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned ID_W      = 8,
   parameter int unsigned TYPE_W    = 2,
   parameter int unsigned PG_SH     = 12,
   parameter logic [(1<<TYPE_W)-1:0] ACC_TYPES = 4'b0110
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [PA_W-1:0]       req_pa,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  enc_mode,
   input  logic [ID_W-1:0]       enc_id,
   input  logic [PA_W-1:0]       prm_lo,
   input  logic [PA_W-1:0]       prm_hi,
   input  logic [PA_W-1:0]       epc_lo,
   input  logic [PA_W-1:0]       epc_hi,
   input  logic                  pm_valid,
   input  logic                  pm_blocked,
   input  logic [TYPE_W-1:0]     pm_type,
   input  logic [ID_W-1:0]       pm_owner,
   input  logic [VA_W-PG_SH-1:0] pm_vpn,
   input  logic [VA_W-1:0]       rng_base,
   input  logic [VA_W-1:0]       rng_mask,
   output logic                  rsp_valid,
   output logic                  rsp_allow,
   output logic                  rsp_fault,
   output logic [2:0]            rsp_code
);
   localparam int unsigned VPN_W = VA_W - PG_SH;

   generate
      if (PG_SH < 1 || PG_SH >= VA_W) begin : g_bad_pg
         $error("etlb_fill_guard: PG_SH must lie inside VA_W");
      end
      if (PA_W <= PG_SH) begin : g_bad_pa
         $error("etlb_fill_guard: PA_W must exceed PG_SH");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("etlb_fill_guard: ID_W must be positive");
      end
   endgenerate

   logic prm_hit, epc_hit, rng_hit;
   logic f_invalid, f_blocked, f_type, f_owner, f_vpage;
   chk_code_e code_d;

   etlb_window #(.AW(PA_W), .STYLE(0)) u_prm_win (
      .addr(req_pa), .bound_a(prm_lo), .bound_b(prm_hi), .hit(prm_hit)
   );

   etlb_window #(.AW(PA_W), .STYLE(0)) u_epc_win (
      .addr(req_pa), .bound_a(epc_lo), .bound_b(epc_hi), .hit(epc_hit)
   );

   etlb_window #(.AW(VA_W), .STYLE(1)) u_rng_win (
      .addr(req_va), .bound_a(rng_base), .bound_b(rng_mask), .hit(rng_hit)
   );

   etlb_page_checks #(
      .ID_W(ID_W), .TYPE_W(TYPE_W), .VPN_W(VPN_W), .ACC_TYPES(ACC_TYPES)
   ) u_page (
      .pm_valid  (pm_valid),
      .pm_blocked(pm_blocked),
      .pm_type   (pm_type),
      .pm_owner  (pm_owner),
      .pm_vpn    (pm_vpn),
      .enc_id    (enc_id),
      .va_vpn    (req_va[VA_W-1:PG_SH]),
      .f_invalid (f_invalid),
      .f_blocked (f_blocked),
      .f_type    (f_type),
      .f_owner   (f_owner),
      .f_vpage   (f_vpage)
   );

   etlb_verdict u_verdict (
      .enc_mode (enc_mode),
      .prm_hit  (prm_hit),
      .epc_hit  (epc_hit),
      .rng_hit  (rng_hit),
      .f_invalid(f_invalid),
      .f_blocked(f_blocked),
      .f_type   (f_type),
      .f_owner  (f_owner),
      .f_vpage  (f_vpage),
      .code     (code_d)
   );

   logic [2:0] code_q;
   logic       vld_q;
   logic       ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         ok_q   <= 1'b0;
         code_q <= 3'd0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            code_q <= code_d;
            ok_q   <= (code_d == CK_OK);
         end
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_code  = code_q;
   assign rsp_allow = vld_q &&  ok_q;
   assign rsp_fault = vld_q && !ok_q;
endmodule

// File: rtl/etlb_fill_guard_chk.sv
module etlb_fill_guard_chk #(
   parameter int unsigned PA_W   = 32,
   parameter int unsigned VA_W   = 32,
   parameter int unsigned ID_W   = 8,
   parameter int unsigned TYPE_W = 2,
   parameter int unsigned PG_SH  = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [PA_W-1:0]       req_pa,
   input logic                  enc_mode,
   input logic [ID_W-1:0]       enc_id,
   input logic [PA_W-1:0]       prm_lo,
   input logic [PA_W-1:0]       prm_hi,
   input logic [PA_W-1:0]       epc_lo,
   input logic [PA_W-1:0]       epc_hi,
   input logic                  pm_valid,
   input logic                  pm_blocked,
   input logic [ID_W-1:0]       pm_owner,
   input logic                  rsp_valid,
   input logic                  rsp_allow,
   input logic                  rsp_fault,
   input logic [2:0]            rsp_code
);
   logic in_prm, in_epc;
   assign in_prm = (req_pa >= prm_lo) && (req_pa < prm_hi);
   assign in_epc = (req_pa >= epc_lo) && (req_pa < epc_hi);

   a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r1_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(rsp_code));
   a_r11_allow_match: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_allow == (rsp_code == 3'd0)) && (rsp_fault == !rsp_allow));
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_allow && !rsp_fault);
   a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_code <= 3'd6);
   a_r3_host_prm: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !enc_mode && in_prm |=> rsp_code == 3'd1);
   a_r4_prm_not_epc: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && enc_mode && in_prm && !in_epc |=> rsp_code == 3'd2);
   a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && enc_mode && in_prm && in_epc && pm_valid && pm_blocked
      |=> rsp_code == 3'd3);
   a_r9_owner_gate: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && enc_mode && (pm_owner == enc_id) |=> rsp_code != 3'd5);
endmodule

bind etlb_fill_guard etlb_fill_guard_chk #(
   .PA_W(PA_W), .VA_W(VA_W), .ID_W(ID_W), .TYPE_W(TYPE_W), .PG_SH(PG_SH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pa(req_pa),
   .enc_mode(enc_mode), .enc_id(enc_id),
   .prm_lo(prm_lo), .prm_hi(prm_hi), .epc_lo(epc_lo), .epc_hi(epc_hi),
   .pm_valid(pm_valid), .pm_blocked(pm_blocked), .pm_owner(pm_owner),
   .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
   .rsp_code(rsp_code)
);

// File: tb/etlb_fill_guard_tb.sv
module etlb_fill_guard_tb;
   localparam int PA_W = 32, VA_W = 32, ID_W = 8, TYPE_W = 2, PG_SH = 12;
   localparam int VPN_W = VA_W - PG_SH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [PA_W-1:0] req_pa = '0;
   logic [VA_W-1:0] req_va = '0;
   logic enc_mode = 1'b0;
   logic [ID_W-1:0] enc_id = '0;
   logic [PA_W-1:0] prm_lo = 32'h8000_0000, prm_hi = 32'h8400_0000;
   logic [PA_W-1:0] epc_lo = 32'h8100_0000, epc_hi = 32'h8300_0000;
   logic pm_valid = 1'b0, pm_blocked = 1'b0;
   logic [TYPE_W-1:0] pm_type = '0;
   logic [ID_W-1:0] pm_owner = '0;
   logic [VPN_W-1:0] pm_vpn = '0;
   logic [VA_W-1:0] rng_base = 32'h4000_0000, rng_mask = 32'h00FF_FFFF;
   logic rsp_valid, rsp_allow, rsp_fault;
   logic [2:0] rsp_code;

   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   etlb_fill_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pa(req_pa),
      .req_va(req_va), .enc_mode(enc_mode), .enc_id(enc_id),
      .prm_lo(prm_lo), .prm_hi(prm_hi), .epc_lo(epc_lo), .epc_hi(epc_hi),
      .pm_valid(pm_valid), .pm_blocked(pm_blocked), .pm_type(pm_type),
      .pm_owner(pm_owner), .pm_vpn(pm_vpn), .rng_base(rng_base),
      .rng_mask(rng_mask), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
      .rsp_fault(rsp_fault), .rsp_code(rsp_code)
   );

   // Expected code derived from the requirement list; tag names the deciding requirement.
   function automatic int exp_code(output string tag);
      bit inprm = (req_pa >= prm_lo) && (req_pa < prm_hi);
      bit inepc = (req_pa >= epc_lo) && (req_pa < epc_hi);
      bit inrng = ((req_va & ~rng_mask) == (rng_base & ~rng_mask));
      if (!enc_mode) begin tag = "R3"; return inprm ? 1 : 0; end
      if (!inprm) begin tag = "R5"; return inrng ? 2 : 0; end
      if (!inepc) begin tag = "R4"; return 2; end
      if (!pm_valid) begin tag = "R6"; return 2; end
      if (pm_blocked) begin tag = "R7"; return 3; end
      if (!(pm_type == 2'd1 || pm_type == 2'd2)) begin tag = "R8"; return 4; end
      if (pm_owner != enc_id) begin tag = "R9"; return 5; end
      tag = "R10";
      return (pm_vpn != req_va[VA_W-1:PG_SH]) ? 6 : 0;
   endfunction

   task automatic check(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Present one request at a negedge, look at the response one negedge later.
   task automatic apply();
      string tag;
      int e;
      e = exp_code(tag);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 valid", rsp_valid === 1'b1, int'(rsp_valid), 1);
      check(tag, rsp_code === 3'(e), int'(rsp_code), e);
      check("R11 allow", rsp_allow === (e == 0), int'(rsp_allow), int'(e == 0));
      check("R11 fault", rsp_fault === (e != 0), int'(rsp_fault), int'(e != 0));
   endtask

   task automatic idle_check();
      logic [2:0] held;
      held = rsp_code;
      enc_mode = 1'b0;
      req_pa = prm_lo;
      pm_blocked = 1'b1;
      @(negedge clk);
      check("R1 idle valid", rsp_valid === 1'b0, int'(rsp_valid), 0);
      check("R1 idle code held", rsp_code === held, int'(rsp_code), int'(held));
      check("R1 idle flags", (rsp_allow | rsp_fault) === 1'b0,
            int'({rsp_allow, rsp_fault}), 0);
   endtask

   // A fully passing enclave request, used as a base for directed cases.
   task automatic good_base();
      enc_mode = 1'b1; enc_id = 8'h3C;
      req_va = 32'h4012_3456; req_pa = 32'h8123_4000;
      pm_valid = 1'b1; pm_blocked = 1'b0; pm_type = 2'd1;
      pm_owner = 8'h3C; pm_vpn = 20'h40123;
   endtask

   task automatic rand_vec();
      int sel;
      sel = $urandom % 8;
      enc_mode = ($urandom % 4) != 0;
      enc_id = 8'($urandom);
      if (sel < 4)       req_pa = epc_lo + ($urandom % (epc_hi - epc_lo));
      else if (sel == 4) req_pa = (($urandom % 2) != 0) ? prm_lo + ($urandom % 32'h0100_0000)
                                                        : epc_hi + ($urandom % 32'h0100_0000);
      else               req_pa = $urandom;
      req_va = (($urandom % 2) != 0) ? (rng_base | ($urandom & rng_mask)) : $urandom;
      pm_valid = ($urandom % 10) != 0;
      pm_blocked = ($urandom % 8) == 0;
      pm_type = (($urandom % 5) != 0) ? 2'(1 + $urandom % 2) : 2'($urandom);
      pm_owner = (($urandom % 7) != 0) ? enc_id : 8'($urandom);
      pm_vpn = (($urandom % 7) != 0) ? req_va[VA_W-1:PG_SH] : 20'($urandom);
   endtask

   initial begin
      void'($urandom(32'h0000_5EED));
      repeat (3) @(negedge clk);
      check("R2 valid", rsp_valid === 1'b0, int'(rsp_valid), 0);
      check("R2 allow", rsp_allow === 1'b0, int'(rsp_allow), 0);
      check("R2 fault", rsp_fault === 1'b0, int'(rsp_fault), 0);
      check("R2 code", rsp_code === 3'd0, int'(rsp_code), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: host access into protected window vs outside it
      enc_mode = 1'b0; req_pa = 32'h83FF_FFFF; apply();
      enc_mode = 1'b0; req_pa = 32'h8400_0000; pm_valid = 1'b0; apply();
      enc_mode = 1'b0; req_pa = 32'h7FFF_FFFF; apply();
      // R4: protected but outside page store, both sides
      good_base(); req_pa = 32'h80FF_F000; apply();
      good_base(); req_pa = 32'h8300_0000; apply();
      // R5: outside protected window, VA inside / outside enclave window
      good_base(); req_pa = 32'h1000_0000; apply();
      good_base(); req_pa = 32'h1000_0000; req_va = 32'h4100_0000; apply();
      // R6 .. R10 one at a time, plus a fully passing fill
      good_base(); apply();
      good_base(); pm_valid = 1'b0; pm_blocked = 1'b1; apply();
      good_base(); pm_blocked = 1'b1; pm_type = 2'd0; apply();
      good_base(); pm_type = 2'd0; pm_owner = 8'h00; apply();
      good_base(); pm_type = 2'd3; apply();
      good_base(); pm_type = 2'd2; pm_owner = 8'h3D; pm_vpn = 20'h0; apply();
      good_base(); pm_vpn = 20'h40124; apply();
      idle_check();

      for (int i = 0; i < 3000; i++) begin
         rand_vec();
         apply();
         if ((i % 17) == 0) idle_check();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule